// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block models a clocked static RAM with burst support and a small internal array. The data word is made of byte lanes, and each lane carries eight data bits plus one parity bit. On every rising clock edge the block decodes its control inputs into a cycle: deselect, read, dummy read, write, write abort or stall. A two-bit burst counter steps the address within an aligned group of four words. The data bus is given as separate input and output vectors plus an active-high drive enable. This maps directly onto an I/O buffer with a tri-state control.

A cycle is either loaded from the external address or advanced from the previous one. Reads are flow-through: the word at the accepted address appears in the cycle that follows the accepting edge. Write data follows one edge behind its address. A clock hold input freezes all state. A sleep input freezes all state and turns the bus off.

Top module: `burst_sram`

## Requirements
- R1: After synchronous reset the block is deselected and `dq_drv` is 0, even with `oe_n` low.
- R2: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A loaded cycle (`advance`=0) with any other combination is a deselect and keeps `dq_drv` at 0. An advanced cycle (`advance`=1) after a deselect stays deselected, whatever the selects are.
- R3: A selected load with `wr_n`=1 and `oe_n`=0 starts a read. In the cycle after the accepting edge, `dq_drv`=1 and `dq_o` holds the stored word at that address.
- R4: `oe_n` gates `dq_drv` combinationally, without waiting for a clock edge. A read with `oe_n`=1 is a dummy read: the bus is not driven, but the read still advances the burst.
- R5: With `advance`=1 on an effective edge, the cycle type is kept and the address steps as (low two bits + 1) mod 4. The upper address bits do not change.
- R6: A selected load with `wr_n`=0 starts a write. `lane_wr_n` is sampled with each address, where bit i=0 enables lane i (`dq_i[9*i+8:9*i]`, with parity in bit 9*i+8). The data on `dq_i` is stored at the following effective edge, lane by lane.
- R7: A write beat with `lane_wr_n` all ones is an abort: the stored word is left unchanged.
- R8: `dq_drv` stays 0 throughout every write cycle, even with `oe_n`=0.
- R9: With `hold`=1 an edge is ignored. Address, cycle type and array contents all keep their values, and a read keeps showing the same word.
- R10: With `sleep`=1 the bus is off (`dq_drv`=0) and every other input is ignored. After sleep ends, the burst resumes from its frozen state.
- R11: A read loaded on the same edge that stores write data at that address returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| sleep | input | 1 | Sleep: bus off, inputs ignored |
| hold | input | 1 | Clock hold: 1 ignores the edge |
| advance | input | 1 | 0 loads a new cycle, 1 continues the burst |
| wr_n | input | 1 | 0 loads a write, 1 loads a read |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External word address |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data toward the bus |
| dq_drv | output | 1 | Bus drive enable, active high |

## Verification
Read data is due in the cycle after the edge that accepts its address. A scoreboard queue receives one expected word for each driven cycle, pushed before that edge, and the monitor compares it 2 ns after the next rising edge. Write data is presented half a cycle before the edge that stores it, and the bench model is updated at that point. The bus-off checks for writes, deselects, dummy reads and sleep are made at falling edges. The asynchronous output-enable check is made 1 ns after `oe_n` changes, with no clock edge in between.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sbs_burst.sv
// Burst address register: load from the pins or step the low bits with wrap.
module sbs_burst #(
  parameter int ADDR_W     = 6,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] addr_q
);
  logic [BURST_BITS-1:0] low_next;

  assign low_next = addr_q[BURST_BITS-1:0] + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (step) begin
      if (load) addr_q <= addr;
      else      addr_q <= {addr_q[ADDR_W-1:BURST_BITS], low_next};
    end
  end
endmodule

// File: rtl/sbs_seq.sv
// Cycle-type register and the lane enables that travel with each address.
module sbs_seq
  import sbs_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic             chip_sel,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output cyc_e             op_q,
  output logic [LANES-1:0] lane_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= CYC_IDLE;
      lane_q <= '0;
    end else if (step) begin
      lane_q <= ~lane_wr_n;
      if (load) begin
        if (!chip_sel) op_q <= CYC_IDLE;
        else if (wr_n) op_q <= CYC_READ;
        else           op_q <= CYC_WRITE;
      end
    end
  end
endmodule

// File: rtl/sbs_array.sv
// Storage split into per-lane memories, written lane by lane, read asynchronously.
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_en,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lane_en[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 2,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    sleep,
  input  logic                    hold,
  input  logic                    advance,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    oe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dq_i,
  output logic [LANES*LANE_W-1:0] dq_o,
  output logic                    dq_drv
);
  localparam int DATA_W = LANES * LANE_W;

  logic              chip_sel, step, load, wr_fire;
  cyc_e              op_q;
  logic [LANES-1:0]  lane_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_word;

  assign chip_sel = !sel_a_n && sel_b && !sel_c_n;
  assign step     = !hold && !sleep;
  assign load     = !advance;
  // Data for the address accepted last edge is stored on this edge.
  assign wr_fire  = step && (op_q == CYC_WRITE);

  sbs_seq #(.LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .step(step), .load(load), .chip_sel(chip_sel),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .op_q(op_q), .lane_q(lane_q)
  );

  sbs_burst #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_burst (
    .clk(clk), .rst(rst), .step(step), .load(load), .addr(addr), .addr_q(addr_q)
  );

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(wr_fire), .lane_en(lane_q), .waddr(addr_q), .wdata(dq_i),
    .raddr(addr_q), .rdata(rd_word)
  );

  // Output enable acts without a clock; writes and sleep keep the bus off.
  assign dq_o   = rd_word;
  assign dq_drv = (op_q == CYC_READ) && !oe_n && !sleep;
endmodule

// File: rtl/sbs_check.sv
module sbs_check
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              hold,
  input logic              advance,
  input logic              oe_n,
  input logic              dq_drv,
  input cyc_e              op_q,
  input logic [ADDR_W-1:0] addr_q
);
  AST_SLEEP_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_drv); // R10

  AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_drv); // R4

  AST_WRITE_BUS_OFF: assert property (@(posedge clk) disable iff (rst)
    (op_q == CYC_WRITE) |-> !dq_drv); // R8

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (hold && !sleep) |=> ($stable(addr_q) && $stable(op_q))); // R9

  AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(addr_q) && $stable(op_q))); // R10

  AST_BURST_WRAP: assert property (@(posedge clk) disable iff (rst)
    (advance && !hold && !sleep) |=>
      (addr_q[1:0] == $past(addr_q[1:0]) + 2'd1) &&
      (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))); // R5

  AST_DESEL_STICKY: assert property (@(posedge clk) disable iff (rst)
    ((op_q == CYC_IDLE) && advance && !hold && !sleep) |=> (op_q == CYC_IDLE)); // R2
endmodule

bind burst_sram sbs_check #(.ADDR_W(ADDR_W)) u_sbs_check (
  .clk(clk), .rst(rst), .sleep(sleep), .hold(hold), .advance(advance),
  .oe_n(oe_n), .dq_drv(dq_drv), .op_q(op_q), .addr_q(addr_q)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
  logic        clk = 0;
  logic        rst = 1;
  logic        sel_a_n = 1, sel_b = 0, sel_c_n = 1;
  logic        sleep = 0, hold = 0, advance = 0, wr_n = 1, oe_n = 0;
  logic [1:0]  lane_wr_n = 2'b11;
  logic [5:0]  addr = '0;
  logic [17:0] dq_i = '0;
  wire  [17:0] dq_o;
  wire         dq_drv;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [17:0] ref_mem [64];
  logic [17:0] exp_q [$];
  logic [5:0]  exp_a [$];
  string       exp_r [$];

  always #5 clk = ~clk; // 10 ns period, 100 MHz

  burst_sram i_burst_sram (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .sleep(sleep), .hold(hold), .advance(advance), .wr_n(wr_n),
    .lane_wr_n(lane_wr_n), .oe_n(oe_n), .addr(addr), .dq_i(dq_i),
    .dq_o(dq_o), .dq_drv(dq_drv)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Scoreboard: expected word for the cycle after the next edge.
  task automatic push(input logic [5:0] a, input string req);
    exp_q.push_back(ref_mem[a]);
    exp_a.push_back(a);
    exp_r.push_back(req);
  endtask

  task automatic ref_write(input logic [5:0] a, input logic [1:0] ln, input logic [17:0] d);
    for (int l = 0; l < 2; l++)
      if (!ln[l]) ref_mem[a][9*l +: 9] = d[9*l +: 9];
  endtask

  task automatic select_on();
    sel_a_n = 0; sel_b = 1; sel_c_n = 0;
  endtask

  task automatic desel_load();
    advance = 0; sel_b = 0; wr_n = 1; lane_wr_n = 2'b11; hold = 0; sleep = 0;
  endtask

  // Monitor: compares driven data 2 ns after each edge.
  always @(posedge clk) begin
    #2;
    if (!rst && dq_drv) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected bus drive", {14'd0, dq_o}, 32'd0);
      end else begin
        logic [17:0] e;
        logic [5:0]  a;
        string       r;
        e = exp_q.pop_front();
        a = exp_a.pop_front();
        r = exp_r.pop_front();
        chk(dq_o === e, $sformatf("%s read addr %0d", r, a), {14'd0, dq_o}, {14'd0, e});
      end
    end
  end

  task automatic wr_burst(input logic [5:0] base, input int n,
                          input logic [1:0] ln [4], input logic [17:0] dv [4]);
    logic [5:0] a;
    a = base;
    @(negedge clk);
    select_on(); advance = 0; wr_n = 0; addr = base; lane_wr_n = ln[0]; oe_n = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(dq_drv == 0, "R8 bus off during write", {31'd0, dq_drv}, 32'd0);
      ref_write(a, ln[i], dv[i]);
      dq_i = dv[i];
      if (i < n - 1) begin
        advance = 1; lane_wr_n = ln[i+1]; a[1:0] = a[1:0] + 2'd1;
      end else begin
        desel_load();
      end
    end
  endtask

  task automatic rd_burst(input logic [5:0] base, input int n, input logic oe, input string req);
    logic [5:0] a;
    a = base;
    @(negedge clk);
    select_on(); advance = 0; wr_n = 1; addr = base; oe_n = oe;
    if (!oe) push(a, req);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (oe) chk(dq_drv == 0, "R4 dummy read bus off", {31'd0, dq_drv}, 32'd0);
      if (i < n) begin
        advance = 1; a[1:0] = a[1:0] + 2'd1;
        if (!oe) push(a, req);
      end else begin
        desel_load(); oe_n = 0;
      end
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    // R1: reset state, output enable active
    repeat (3) @(negedge clk);
    chk(dq_drv == 0, "R1 bus off in reset", {31'd0, dq_drv}, 32'd0);
    rst = 0;
    select_on(); advance = 1; // continue deselect with valid selects
    @(negedge clk);
    chk(dq_drv == 0, "R1 deselected after reset", {31'd0, dq_drv}, 32'd0);
    desel_load();

    // R6: full-lane burst write, then R3 burst read
    wr_burst(6'd8, 4, '{2'b00, 2'b00, 2'b00, 2'b00},
             '{18'h2A1B3, 18'h15C4D, 18'h3F00E, 18'h0ABCD});
    rd_burst(6'd8, 4, 1'b0, "R3");

    // R5: burst starting mid-group wraps to 8
    rd_burst(6'd10, 4, 1'b0, "R5 wrap");

    // R6/R7: mixed lane enables including an aborted beat
    wr_burst(6'd16, 4, '{2'b00, 2'b00, 2'b00, 2'b00},
             '{18'h11111, 18'h22222, 18'h33333, 18'h04444});
    wr_burst(6'd16, 4, '{2'b10, 2'b01, 2'b11, 2'b00},
             '{18'h3FFFF, 18'h2AAAA, 18'h15555, 18'h0F0F0});
    rd_burst(6'd16, 4, 1'b0, "R6 lanes");

    // R7: single aborted write leaves address 8 unchanged
    wr_burst(6'd8, 1, '{2'b11, 2'b11, 2'b11, 2'b11},
             '{18'h00BAD, 18'h0, 18'h0, 18'h0});
    rd_burst(6'd8, 1, 1'b0, "R7 abort");

    // R4: dummy read burst, then output enable acting without a clock
    rd_burst(6'd8, 3, 1'b1, "R4");
    @(negedge clk);
    select_on(); advance = 0; wr_n = 1; addr = 6'd9; oe_n = 1;
    @(negedge clk);
    chk(dq_drv == 0, "R4 oe high bus off", {31'd0, dq_drv}, 32'd0);
    oe_n = 0;
    #1;
    chk(dq_drv == 1, "R4 oe low drives at once", {31'd0, dq_drv}, 32'd1);
    chk(dq_o === ref_mem[9], "R4 oe low data", {14'd0, dq_o}, {14'd0, ref_mem[9]});
    desel_load();

    // R9: stall in the middle of a read burst
    @(negedge clk);
    select_on(); advance = 0; wr_n = 1; addr = 6'd16; push(6'd16, "R9");
    @(negedge clk);
    advance = 1; push(6'd17, "R9");
    @(negedge clk);
    hold = 1; push(6'd17, "R9 hold");
    @(negedge clk);
    advance = 0; addr = 6'd40; wr_n = 0; lane_wr_n = 2'b00; push(6'd17, "R9 hold");
    @(negedge clk);
    hold = 0; advance = 1; wr_n = 1; lane_wr_n = 2'b11; push(6'd18, "R9 resume");
    @(negedge clk);
    desel_load();

    // R10: sleep during a read burst
    @(negedge clk);
    select_on(); advance = 0; wr_n = 1; addr = 6'd8; push(6'd8, "R10");
    @(negedge clk);
    sleep = 1; advance = 0; wr_n = 0; addr = 6'd33; lane_wr_n = 2'b00; dq_i = 18'h3DEAD;
    #1;
    chk(dq_drv == 0, "R10 sleep bus off", {31'd0, dq_drv}, 32'd0);
    @(negedge clk);
    chk(dq_drv == 0, "R10 sleep edge ignored", {31'd0, dq_drv}, 32'd0);
    sleep = 0; advance = 1; wr_n = 1; lane_wr_n = 2'b11; push(6'd9, "R10 resume");
    @(negedge clk);
    desel_load();

    // R2: loaded deselect, then continued deselect with valid selects
    @(negedge clk);
    sel_a_n = 0; sel_b = 1; sel_c_n = 1; advance = 0; wr_n = 1; addr = 6'd8;
    @(negedge clk);
    chk(dq_drv == 0, "R2 deselect by sel_c_n", {31'd0, dq_drv}, 32'd0);
    select_on(); advance = 1;
    @(negedge clk);
    chk(dq_drv == 0, "R2 continued deselect", {31'd0, dq_drv}, 32'd0);
    desel_load();

    // R11: read loaded on the edge that stores write data
    @(negedge clk);
    select_on(); advance = 0; wr_n = 0; addr = 6'd20; lane_wr_n = 2'b00;
    @(negedge clk);
    dq_i = 18'h1C0DE; ref_write(6'd20, 2'b00, 18'h1C0DE);
    wr_n = 1; lane_wr_n = 2'b11; addr = 6'd20; push(6'd20, "R11");
    @(negedge clk);
    desel_load();

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected reads seen", exp_q.size(), 32'd0);
    finish_run();
  end
endmodule